// File: doc/BRIEF.md
# Shifted-Register AND Execution Unit

This unit executes a 64-bit bitwise AND in which the second operand is a register value modified by an immediate shift before the logic operation. It accepts a 32-bit instruction word together with the two register-read values that the surrounding pipeline has already fetched. From the instruction word it extracts the destination index, both source indices, a 2-bit shift kind and a 6-bit shift amount.

The second operand passes through a built-in shifter that can shift left, shift right with zero fill, shift right with sign fill, or rotate right. The result is ANDed with the first operand. One clock later the unit presents the 64-bit result, a valid strobe that doubles as the register write enable, and the destination index. A source index of 31 selects the zero register, so that operand contributes zero whatever value was supplied for it.

Top module: `shreg_and_unit`

## Requirements
- R1: After reset, and until the first accepted input, `wr_en` is 0 and `wr_data` and `wr_idx` are 0.
- R2: The destination index comes from instruction bits 4:0, the first source index from bits 9:5 and the second source index from bits 20:16. `wr_idx` equals bits 4:0 of the accepted word.
- R3: Shift kind 00 (instruction bits 23:22) shifts the second operand left by the amount in bits 15:10 and fills the low bits with zeros.
- R4: Shift kind 01 shifts the second operand right by the amount and fills the high bits with zeros.
- R5: Shift kind 10 shifts the second operand right by the amount and fills the vacated high bits with copies of bit 63.
- R6: Shift kind 11 rotates the second operand right by the amount. Bits that leave the bottom re-enter at the top.
- R7: A shift amount of 0 leaves the second operand unchanged for all four kinds.
- R8: A source index of 31 in either source field makes that operand read as zero.
- R9: `wr_data` is the full 64-bit AND of the first operand and the shifted second operand.
- R10: Results appear one cycle after `in_valid`, with `wr_en` high for exactly that cycle. A cycle without `in_valid` gives `wr_en` low the next cycle, and `wr_data` and `wr_idx` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| insn | input | 32 | Instruction word |
| rs_a_val | input | 64 | Value read for the first source index |
| rs_b_val | input | 64 | Value read for the second source index |
| wr_en | output | 1 | Result valid / register write enable |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | 64 | AND result |

## Verification
The bench runs all four shift kinds at every amount from 0 to 63 against four second-operand patterns. A pattern with both ends set and a near-all-ones pattern with its top bit clear separate zero fill from sign fill and rotation. Two mixed patterns catch an off-by-one in the amount or a wrong fill direction. With a first operand of all ones the shifter output can be seen directly, and a striped first operand shows that the AND covers all 64 bits. Separate runs use index 31 in each source field to check the zero register, and an idle cycle checks that the outputs hold.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic [1:0] {
    SK_LEFT  = 2'b00,
    SK_RIGHT = 2'b01,
    SK_ARITH = 2'b10,
    SK_ROT   = 2'b11
  } shift_kind_e;

  typedef struct packed {
    logic [4:0]  dest;
    logic [4:0]  src_a;
    logic [4:0]  src_b;
    logic [5:0]  amount;
    shift_kind_e kind;
  } op_fields_t;
endpackage

// File: rtl/field_decode.sv
module field_decode
  import shreg_pkg::*;
(
  input  logic [31:0] insn,
  output op_fields_t  fields
);
  always_comb begin
    fields.dest   = insn[4:0];
    fields.src_a  = insn[9:5];
    fields.src_b  = insn[20:16];
    fields.amount = insn[15:10];
    fields.kind   = shift_kind_e'(insn[23:22]);
  end
endmodule

// File: rtl/operand_gate.sv
module operand_gate #(
  parameter int W        = 64,
  parameter int IDX_W    = 5,
  parameter int ZERO_IDX = 31
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     raw,
  output logic [W-1:0]     gated,
  output logic             is_zero_reg
);
  assign is_zero_reg = (idx == IDX_W'(ZERO_IDX));
  assign gated       = is_zero_reg ? '0 : raw;
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter #(
  parameter int W  = 64,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [1:0]    kind,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  shifted
);
  localparam int NKIND = 4;

  function automatic logic [W-1:0] shift_by_kind(input logic [W-1:0] v,
                                                 input int k,
                                                 input logic [AW-1:0] n);
    logic [2*W-1:0] doubled;
    doubled = {v, v} >> n;
    case (k)
      0:       return v << n;
      1:       return v >> n;
      2:       return W'($signed(v) >>> n);
      default: return doubled[W-1:0];
    endcase
  endfunction

  logic [W-1:0] cand [NKIND];

  for (genvar g = 0; g < NKIND; g++) begin : g_kind
    assign cand[g] = shift_by_kind(val, g, amt);
  end

  assign shifted = cand[kind];
endmodule

// File: rtl/result_stage.sv
module result_stage #(
  parameter int W     = 64,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] dest_in,
  input  logic [W-1:0]     data_in,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [W-1:0]     wr_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= in_valid;
      if (in_valid) begin
        wr_idx  <= dest_in;
        wr_data <= data_in;
      end
    end
  end

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!wr_en && $stable(wr_data) && $stable(wr_idx)));
  // R2
  dest_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (wr_en && wr_idx == $past(dest_in)));
endmodule

// File: rtl/shreg_and_unit.sv
module shreg_and_unit
  import shreg_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int IDX_W    = 5,
  parameter int ZERO_IDX = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       insn,
  input  logic [DATA_W-1:0] rs_a_val,
  input  logic [DATA_W-1:0] rs_b_val,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data
);
  localparam int AMT_W = $clog2(DATA_W);

  op_fields_t        fields;
  logic [DATA_W-1:0] op_a, op_b, op_b_shifted, and_result;
  logic              a_is_zero, b_is_zero;

  field_decode u_decode (.insn(insn), .fields(fields));

  operand_gate #(.W(DATA_W), .IDX_W(IDX_W), .ZERO_IDX(ZERO_IDX)) u_gate_a (
    .idx(fields.src_a), .raw(rs_a_val), .gated(op_a), .is_zero_reg(a_is_zero));

  operand_gate #(.W(DATA_W), .IDX_W(IDX_W), .ZERO_IDX(ZERO_IDX)) u_gate_b (
    .idx(fields.src_b), .raw(rs_b_val), .gated(op_b), .is_zero_reg(b_is_zero));

  operand_shifter #(.W(DATA_W), .AW(AMT_W)) u_shift (
    .val(op_b), .kind(fields.kind), .amt(fields.amount[AMT_W-1:0]),
    .shifted(op_b_shifted));

  assign and_result = op_a & op_b_shifted;

  result_stage #(.W(DATA_W), .IDX_W(IDX_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dest_in(fields.dest),
    .data_in(and_result), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data));

  // R7
  zero_amt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fields.amount == '0) |-> op_b_shifted == op_b);
  // R6
  rot_popcount_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fields.kind == SK_ROT) |->
      $countones(op_b_shifted) == $countones(op_b));
  // R5
  arith_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fields.kind == SK_ARITH) |->
      op_b_shifted[DATA_W-1] == op_b[DATA_W-1]);
  // R4
  right_topzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fields.kind == SK_RIGHT && fields.amount != '0) |->
      !op_b_shifted[DATA_W-1]);
  // R3
  left_lowzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fields.kind == SK_LEFT && fields.amount != '0) |->
      !op_b_shifted[0]);
  // R8
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (a_is_zero || b_is_zero)) |=> (wr_data == '0));
  // R9
  and_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (wr_data & ~$past(op_a)) == '0);
endmodule

// File: tb/shreg_and_unit_test.sv
module shreg_and_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] rs_a_val = '0, rs_b_val = '0;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [63:0] wr_data;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  shreg_and_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .rs_a_val(rs_a_val), .rs_b_val(rs_b_val),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data));

  function automatic logic [63:0] model_shift(logic [63:0] v, int k, int n);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) begin
      case (k)
        0: r[i] = (i >= n) ? v[i-n] : 1'b0;
        1: r[i] = (i + n < 64) ? v[i+n] : 1'b0;
        2: r[i] = (i + n < 64) ? v[i+n] : v[63];
        default: r[i] = v[(i+n)%64];
      endcase
    end
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_op(int k, int n, logic [63:0] a, logic [63:0] b,
                        int ia, int ib, int dst, string tag);
    logic [63:0] ea, eb, exp;
    @(negedge clk);
    insn = {8'(dst * 7 + n), 2'(k), 1'(n), 5'(ib), 6'(n), 5'(ia), 5'(dst)};
    rs_a_val = a;
    rs_b_val = b;
    in_valid = 1'b1;
    ea = (ia == 31) ? 64'd0 : a;
    eb = (ib == 31) ? 64'd0 : b;
    exp = ea & model_shift(eb, k, n);
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, wr_data, exp);
    check("R10 wr_en", {63'd0, wr_en}, 64'd1);
    check("R2 wr_idx", {59'd0, wr_idx}, 64'(dst));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] bpat [4];
    logic [63:0] held;
    string tags [4];
    bpat[0] = 64'h8000_0000_0000_0001;
    bpat[1] = 64'h7FFF_FFFF_FFFF_FFFE;
    bpat[2] = 64'hF0E1_D2C3_B4A5_9687;
    bpat[3] = 64'h0123_4567_89AB_CDEF;
    tags[0] = "R3 left";
    tags[1] = "R4 right";
    tags[2] = "R5 arith";
    tags[3] = "R6 rotate";

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 wr_en", {63'd0, wr_en}, 64'd0);
    check("R1 wr_data", wr_data, 64'd0);
    check("R1 wr_idx", {59'd0, wr_idx}, 64'd0);
    rst_n = 1'b1;

    // R3 R4 R5 R6 R7 R9: full sweep
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 4; k++)
        for (int n = 0; n < 64; n++)
          run_op(k, n, (p == 3) ? 64'hFFFF_0000_FF00_F0F0 : '1, bpat[p],
                 (n + 3) % 31, (n + 11) % 31, (n + k + p) % 32,
                 (n == 0) ? "R7 zero amount" : ((p == 3) ? "R9 and" : tags[k]));

    // R8: zero register on either source
    for (int k = 0; k < 4; k++) begin
      run_op(k, 5, '1, bpat[2], 31, 4, 9, "R8 src_a zero");
      run_op(k, 5, '1, bpat[2], 4, 31, 10, "R8 src_b zero");
    end

    // R10: idle cycle holds outputs
    run_op(3, 17, '1, bpat[3], 1, 2, 22, "R6 rotate");
    held = wr_data;
    @(negedge clk);
    check("R10 idle wr_en", {63'd0, wr_en}, 64'd0);
    check("R10 idle data", wr_data, held);
    check("R10 idle idx", {59'd0, wr_idx}, 64'd22);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule